// File: doc/BRIEF.md
# Merged Three-Input Sum-of-Squares Unit

This unit takes three unsigned 8-bit gradient components and returns the sum of their squares. It does not square each operand and then add the three results. Each operand instead forms a folded squaring matrix. Every cross product xi·xj with i<j is kept once, one column to the left, and each diagonal product xi·xi is replaced by the bit xi alone. The three folded matrices are packed into one set of columns, so the tallest column holds 15 bits. One shared compressor tree then reduces them. That tree uses a layer of 3:2 counters and 4:2 compressors, followed by two more layers of 4:2 compressors. The squaring and the summation therefore take place in the same reduction.

The tree's redundant output, a pair of sum and carry vectors, is registered and brought out on its own ports. A downstream leading-one detector can start on it while the final carry-propagate adder is still working. That adder is built from 4-bit ripple groups with a skip path around each group, and its 18-bit result is registered once more. A strobe that accompanies the operands travels with them. The strobe enables each register stage, so a stage keeps its contents in any cycle that carries no new data.

Top module: `sqsum3`

## Requirements
- R1: Two cycles after a strobe, `sum_out` equals a² + b² + c² as an 18-bit value. Here a is `comp_in[7:0]`, b is `comp_in[15:8]` and c is `comp_in[23:16]`.
- R2: `red_vld` is high exactly one cycle after each clock in which `in_vld` was high, and `sum_vld` is high exactly two cycles after it. In every other cycle both are low.
- R3: In the cycle `red_vld` is high, (`red_sum` + `red_cry`) mod 2^18 equals the sum of squares of the operands strobed one cycle earlier.
- R4: When `in_vld` is low, `red_sum` and `red_cry` keep their values whatever `comp_in` does. When `red_vld` is low, `sum_out` keeps its value.
- R5: Driving `rst_n` low clears `red_vld`, `sum_vld`, `red_sum`, `red_cry` and `sum_out` at once, without waiting for a clock edge. After `rst_n` is released, strobes are accepted from the third rising edge on.
- R6: Strobes on consecutive cycles each produce their own result on consecutive cycles, with no bubble between them.
- R7: All three operands at 255 give 195075, and `sum_out` never exceeds 195075 while `sum_vld` is high.
- R8: All three operands at zero give a result of 0, and `sum_vld` is still asserted for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, release is synchronised inside |
| in_vld | input | 1 | Operand strobe |
| comp_in | input | 24 | Three 8-bit operands, a in [7:0], b in [15:8], c in [23:16] |
| red_vld | output | 1 | Redundant pair valid (one cycle after the strobe) |
| red_sum | output | 18 | Sum vector of the compressor tree |
| red_cry | output | 18 | Carry vector of the compressor tree |
| sum_vld | output | 1 | Final result valid (two cycles after the strobe) |
| sum_out | output | 18 | Final sum of squares |

## Verification
The redundant pair of one operand set and the final sum of the previous set appear in the same cycle whenever strobes come back to back. That is the case where a mix-up between the two pipeline stages would show. The vector table and a random stream with strobe gaps drive exactly this overlap. At each sampling point the bench judges the redundant pair against the newer vector's expected value and `sum_out` against the older one. The gaps are what check that each stage holds its data on its own enable, independently of the other.

// File: rtl/sqsum3_pkg.sv
`timescale 1ns/1ps
package sqsum3_pkg;

  // Number of partial-product bits that land in one column of the merged
  // folded-squarer array (nin squarers of n-bit operands).
  function automatic int col_height(input int n, input int nin, input int col);
    int h;
    h = 0;
    for (int i = 0; i < n; i++) begin
      if (2 * i == col) h++;
      for (int j = i + 1; j < n; j++) begin
        if (i + j + 1 == col) h++;
      end
    end
    return h * nin;
  endfunction

  // Tallest column of the merged array.
  function automatic int max_height(input int n, input int nin);
    int m;
    m = 0;
    for (int c = 0; c < 2 * n; c++) begin
      if (col_height(n, nin, c) > m) m = col_height(n, nin, c);
    end
    return m;
  endfunction

  // Row count rounded up so that 4:2 layers halve it evenly.
  function automatic int pad_rows(input int rows);
    int p;
    p = 4;
    while (p < rows) p = p * 2;
    return p;
  endfunction

endpackage

// File: rtl/sqsum3_ppg.sv
`timescale 1ns/1ps
// Folded squarer partial products of all operands, packed column by column
// into ROWS rows so that row r holds the r-th bit of every column.
module sqsum3_ppg #(
  parameter int IN_W   = 8,
  parameter int NUM_IN = 3,
  parameter int SUM_W  = 18,
  parameter int ROWS   = 15
) (
  input  logic [NUM_IN*IN_W-1:0]     opnd,
  output logic [ROWS-1:0][SUM_W-1:0] rows
);

  int fill [SUM_W];

  always_comb begin
    rows = '0;
    for (int c = 0; c < SUM_W; c++) fill[c] = 0;
    for (int s = 0; s < NUM_IN; s++) begin
      for (int i = 0; i < IN_W; i++) begin
        // diagonal term xi*xi collapses to xi at weight 2i
        rows[fill[2*i]][2*i] = opnd[s*IN_W + i];
        fill[2*i]++;
        // each cross term appears once, moved one column left
        for (int j = i + 1; j < IN_W; j++) begin
          rows[fill[i+j+1]][i+j+1] = opnd[s*IN_W + i] & opnd[s*IN_W + j];
          fill[i+j+1]++;
        end
      end
    end
  end

endmodule

// File: rtl/sqsum3_csa.sv
`timescale 1ns/1ps
// Row-wide 3:2 counter: three vectors in, sum and shifted carry out.
module sqsum3_csa #(
  parameter int W = 18
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s,
  output logic [W-1:0] k
);

  assign s = a ^ b ^ c;
  assign k = {(a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) | (b[W-2:0] & c[W-2:0]), 1'b0};

endmodule

// File: rtl/sqsum3_c42.sv
`timescale 1ns/1ps
// Row-wide 4:2 compressor; the inner carry of each column feeds the next
// column's second adder through the shifted intermediate vector.
module sqsum3_c42 #(
  parameter int W = 18
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] k
);

  logic [W-1:0] mid_s;
  logic [W-1:0] mid_k;

  sqsum3_csa #(.W(W)) u_lo (.a(a),     .b(b), .c(c),     .s(mid_s), .k(mid_k));
  sqsum3_csa #(.W(W)) u_hi (.a(mid_s), .b(d), .c(mid_k), .s(s),     .k(k));

endmodule

// File: rtl/sqsum3_tree.sv
`timescale 1ns/1ps
// Shared reduction tree: first layer mixes 4:2 compressors with a 3:2
// counter where a group is short of rows, later layers are all 4:2.
module sqsum3_tree #(
  parameter int W    = 18,
  parameter int ROWS = 15,
  parameter int PAD  = 16
) (
  input  logic [ROWS-1:0][W-1:0] rows,
  output logic [W-1:0]           sum_v,
  output logic [W-1:0]           cry_v
);

  localparam int LVL = $clog2(PAD) - 1;

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    localparam int NI = PAD >> l;
    localparam int NO = NI / 2;
    logic [NO-1:0][W-1:0] vout;

    for (genvar g = 0; g < NI / 4; g++) begin : g_grp
      if (l == 0) begin : g_first
        if (4*g + 3 < ROWS) begin : g_four
          sqsum3_c42 #(.W(W)) u_c42 (
            .a(rows[4*g]), .b(rows[4*g+1]), .c(rows[4*g+2]), .d(rows[4*g+3]),
            .s(vout[2*g]), .k(vout[2*g+1]));
        end else if (4*g + 2 < ROWS) begin : g_three
          sqsum3_csa #(.W(W)) u_csa (
            .a(rows[4*g]), .b(rows[4*g+1]), .c(rows[4*g+2]),
            .s(vout[2*g]), .k(vout[2*g+1]));
        end else if (4*g + 1 < ROWS) begin : g_two
          assign vout[2*g]   = rows[4*g];
          assign vout[2*g+1] = rows[4*g+1];
        end else if (4*g < ROWS) begin : g_one
          assign vout[2*g]   = rows[4*g];
          assign vout[2*g+1] = '0;
        end else begin : g_none
          assign vout[2*g]   = '0;
          assign vout[2*g+1] = '0;
        end
      end else begin : g_next
        sqsum3_c42 #(.W(W)) u_c42 (
          .a(g_lvl[l-1].vout[4*g]),   .b(g_lvl[l-1].vout[4*g+1]),
          .c(g_lvl[l-1].vout[4*g+2]), .d(g_lvl[l-1].vout[4*g+3]),
          .s(vout[2*g]), .k(vout[2*g+1]));
      end
    end
  end

  assign sum_v = g_lvl[LVL-1].vout[0];
  assign cry_v = g_lvl[LVL-1].vout[1];

endmodule

// File: rtl/sqsum3_cpa.sv
`timescale 1ns/1ps
// Carry-propagate adder from GRP-bit ripple groups, each with a skip path
// that passes the incoming carry when the whole group propagates.
module sqsum3_cpa #(
  parameter int W   = 18,
  parameter int GRP = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);

  localparam int NG = (W + GRP - 1) / GRP;

  logic [W-1:0]  pp;
  logic [W-2:0]  gn;
  logic [W-1:0]  cb;
  logic [NG-1:0] cg;

  assign pp    = a ^ b;
  assign cg[0] = 1'b0;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LO = g * GRP;
    localparam int HI = (LO + GRP > W) ? W - 1 : LO + GRP - 1;

    for (genvar k = LO; k <= HI; k++) begin : g_bit
      if (k < W - 1) begin : g_gen
        assign gn[k] = a[k] & b[k];
      end
      if (k == LO) begin : g_head
        assign cb[k] = cg[g];
      end else begin : g_body
        assign cb[k] = gn[k-1] | (pp[k-1] & cb[k-1]);
      end
      assign s[k] = pp[k] ^ cb[k];
    end

    if (g < NG - 1) begin : g_skip
      logic rip;
      assign rip       = gn[HI] | (pp[HI] & cb[HI]);
      assign cg[g+1]   = (&pp[HI:LO]) ? cg[g] : rip;
    end
  end

endmodule

// File: rtl/sqsum3_rsync.sv
`timescale 1ns/1ps
// Reset that asserts at once and deasserts on the second clock edge.
module sqsum3_rsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sr_q;
  logic [1:0] sr_d;

  always_comb sr_d = {sr_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[1];

endmodule

// File: rtl/sqsum3.sv
`timescale 1ns/1ps
module sqsum3 #(
  parameter  int IN_W   = 8,
  parameter  int NUM_IN = 3,
  localparam int SUM_W  = 2 * IN_W + $clog2(NUM_IN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld,
  input  logic [NUM_IN*IN_W-1:0] comp_in,
  output logic                   red_vld,
  output logic [SUM_W-1:0]       red_sum,
  output logic [SUM_W-1:0]       red_cry,
  output logic                   sum_vld,
  output logic [SUM_W-1:0]       sum_out
);

  import sqsum3_pkg::*;

  localparam int ROWS = max_height(IN_W, NUM_IN);
  localparam int PAD  = pad_rows(ROWS);

  logic rst_sync_n;

  logic [ROWS-1:0][SUM_W-1:0] pp_rows;
  logic [SUM_W-1:0]           tree_s;
  logic [SUM_W-1:0]           tree_c;
  logic [SUM_W-1:0]           cpa_s;

  logic             s1_vld_q, s1_vld_d;
  logic [SUM_W-1:0] s1_sum_q, s1_sum_d;
  logic [SUM_W-1:0] s1_cry_q, s1_cry_d;
  logic             s2_vld_q, s2_vld_d;
  logic [SUM_W-1:0] s2_sum_q, s2_sum_d;

  sqsum3_rsync u_rsync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  sqsum3_ppg #(.IN_W(IN_W), .NUM_IN(NUM_IN), .SUM_W(SUM_W), .ROWS(ROWS)) u_ppg (
    .opnd(comp_in), .rows(pp_rows));

  sqsum3_tree #(.W(SUM_W), .ROWS(ROWS), .PAD(PAD)) u_tree (
    .rows(pp_rows), .sum_v(tree_s), .cry_v(tree_c));

  sqsum3_cpa #(.W(SUM_W), .GRP(4)) u_cpa (
    .a(s1_sum_q), .b(s1_cry_q), .s(cpa_s));

  // next state: each stage loads only when its own strobe is present
  always_comb begin
    s1_vld_d = in_vld;
    s1_sum_d = in_vld ? tree_s : s1_sum_q;
    s1_cry_d = in_vld ? tree_c : s1_cry_q;
    s2_vld_d = s1_vld_q;
    s2_sum_d = s1_vld_q ? cpa_s : s2_sum_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_vld_q <= 1'b0;
      s1_sum_q <= '0;
      s1_cry_q <= '0;
      s2_vld_q <= 1'b0;
      s2_sum_q <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s1_sum_q <= s1_sum_d;
      s1_cry_q <= s1_cry_d;
      s2_vld_q <= s2_vld_d;
      s2_sum_q <= s2_sum_d;
    end
  end

  assign red_vld = s1_vld_q;
  assign red_sum = s1_sum_q;
  assign red_cry = s1_cry_q;
  assign sum_vld = s2_vld_q;
  assign sum_out = s2_sum_q;

endmodule

// File: rtl/sqsum3_chk.sv
`timescale 1ns/1ps
module sqsum3_chk #(
  parameter  int IN_W   = 8,
  parameter  int NUM_IN = 3,
  localparam int SUM_W  = 2 * IN_W + $clog2(NUM_IN)
) (
  input logic                   clk,
  input logic                   rst_ok,
  input logic                   in_vld,
  input logic [NUM_IN*IN_W-1:0] comp_in,
  input logic                   red_vld,
  input logic [SUM_W-1:0]       red_sum,
  input logic [SUM_W-1:0]       red_cry,
  input logic                   sum_vld,
  input logic [SUM_W-1:0]       sum_out
);

  localparam int MAXV = NUM_IN * ((1 << IN_W) - 1) * ((1 << IN_W) - 1);

  logic [SUM_W-1:0] ref_v;
  logic [SUM_W-1:0] red_tot;

  always_comb begin
    ref_v = '0;
    for (int k = 0; k < NUM_IN; k++) begin
      ref_v = ref_v + SUM_W'(comp_in[k*IN_W +: IN_W]) * SUM_W'(comp_in[k*IN_W +: IN_W]);
    end
  end

  assign red_tot = red_sum + red_cry;

  // R3
  redundant_pair_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    in_vld |=> (red_tot == $past(ref_v)));

  // R1
  final_sum_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    red_vld |=> (sum_out == $past(red_tot)));

  // R2
  first_stage_vld_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    in_vld |=> red_vld);

  // R2
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_vld |=> !red_vld);

  // R2
  second_stage_vld_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    red_vld |=> sum_vld);

  // R4
  red_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_vld |=> ($stable(red_sum) && $stable(red_cry)));

  // R4
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !red_vld |=> ($stable(sum_out) && !sum_vld));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    sum_vld |-> (sum_out <= SUM_W'(MAXV)));

endmodule

bind sqsum3 sqsum3_chk #(.IN_W(IN_W), .NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .in_vld(in_vld), .comp_in(comp_in),
  .red_vld(red_vld), .red_sum(red_sum), .red_cry(red_cry),
  .sum_vld(sum_vld), .sum_out(sum_out));

// File: tb/sqsum3_tb.sv
`timescale 1ns/1ps
module sqsum3_tb;

  localparam int NV = 12;

  // {c, b, a, expected}
  localparam logic [41:0] TBL [NV] = '{
    {8'd0,   8'd0,   8'd0,   18'd0},
    {8'd255, 8'd255, 8'd255, 18'd195075},
    {8'd3,   8'd2,   8'd1,   18'd14},
    {8'd0,   8'd0,   8'd128, 18'd16384},
    {8'd0,   8'd255, 8'd0,   18'd65025},
    {8'd50,  8'd200, 8'd100, 18'd52500},
    {8'd51,  8'd34,  8'd17,  18'd4046},
    {8'd0,   8'd255, 8'd255, 18'd130050},
    {8'd85,  8'd240, 8'd15,  18'd65050},
    {8'd1,   8'd1,   8'd1,   18'd3},
    {8'd204, 8'd85,  8'd170, 18'd77741},
    {8'd255, 8'd0,   8'd0,   18'd65025}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [23:0] comp_in;
  logic        red_vld;
  logic [17:0] red_sum;
  logic [17:0] red_cry;
  logic        sum_vld;
  logic [17:0] sum_out;
  logic [17:0] red_tot;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sqsum3 u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .comp_in(comp_in),
    .red_vld(red_vld), .red_sum(red_sum), .red_cry(red_cry),
    .sum_vld(sum_vld), .sum_out(sum_out));

  assign red_tot = red_sum + red_cry;

  function automatic int model(input logic [23:0] v);
    int s;
    s = 0;
    for (int k = 0; k < 3; k++) s = s + int'(v[k*8 +: 8]) * int'(v[k*8 +: 8]);
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int          e1;
    int          e2;
    bit          v1;
    bit          v2;
    bit          vld;
    logic [31:0] lf;
    int          last_sum;
    int          last_red;

    rst_n   = 1'b0;
    in_vld  = 1'b0;
    comp_in = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R5: state after reset
    chk("R5 red_vld", int'(red_vld), 0);
    chk("R5 sum_vld", int'(sum_vld), 0);
    chk("R5 sum_out", int'(sum_out), 0);
    chk("R5 red pair", int'(red_tot), 0);

    // R1 R3 R6 R7 R8: table streamed back to back
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 1 && i <= NV) begin
        chk("R6 red_vld", int'(red_vld), 1);
        chk("R3 red pair", int'(red_tot), int'(TBL[i-1][17:0]));
      end
      if (i >= 2) begin
        chk("R6 sum_vld", int'(sum_vld), 1);
        if (TBL[i-2][17:0] == 18'd195075)
          chk("R7 all-255 sum", int'(sum_out), int'(TBL[i-2][17:0]));
        else if (TBL[i-2][17:0] == 18'd0)
          chk("R8 zero sum", int'(sum_out), 0);
        else
          chk("R1 sum", int'(sum_out), int'(TBL[i-2][17:0]));
      end
      if (i < NV) begin
        in_vld  = 1'b1;
        comp_in = TBL[i][41:18];
      end else begin
        in_vld = 1'b0;
      end
      tick();
    end
    chk("R2 sum_vld drops", int'(sum_vld), 0);
    chk("R4 sum held", int'(sum_out), int'(TBL[NV-1][17:0]));

    // R4: operand changes without strobe have no effect
    last_sum = int'(sum_out);
    last_red = int'(red_tot);
    lf = 32'h1D2C_3B4A;
    for (int i = 0; i < 6; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      comp_in = lf[23:0];
      in_vld  = 1'b0;
      tick();
      chk("R4 sum_out hold", int'(sum_out), last_sum);
      chk("R4 red pair hold", int'(red_tot), last_red);
      chk("R4 red_vld low", int'(red_vld), 0);
    end

    // R2: a single strobe gives one-cycle valid pulses at +1 and +2
    comp_in = {8'd9, 8'd7, 8'd5};
    in_vld  = 1'b1;
    tick();
    in_vld = 1'b0;
    chk("R2 red_vld at +1", int'(red_vld), 1);
    chk("R2 sum_vld at +1", int'(sum_vld), 0);
    tick();
    chk("R2 red_vld at +2", int'(red_vld), 0);
    chk("R2 sum_vld at +2", int'(sum_vld), 1);
    chk("R1 small sum", int'(sum_out), 155);
    tick();
    chk("R2 sum_vld at +3", int'(sum_vld), 0);
    chk("R4 sum after pulse", int'(sum_out), 155);

    // R1 R3 R4 R6: random stream with gaps
    e1 = 155;
    e2 = 155;
    v1 = 1'b0;
    v2 = 1'b0;
    for (int i = 0; i < 400; i++) begin
      chk("R2 red_vld stream", int'(red_vld), int'(v1));
      chk("R3 red pair stream", int'(red_tot), e1);
      chk("R2 sum_vld stream", int'(sum_vld), int'(v2));
      chk("R1 sum stream", int'(sum_out), e2);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      vld = lf[3] | lf[7];
      comp_in = {lf[31:24] ^ lf[7:0], lf[23:8]};
      in_vld  = vld;
      if (v1) e2 = e1;
      v2 = v1;
      v1 = vld;
      if (vld) e1 = model(comp_in);
      tick();
    end
    in_vld = 1'b0;

    // R5: asynchronous clear in mid-flight
    comp_in = 24'hFF_FFFF;
    in_vld  = 1'b1;
    tick();
    in_vld = 1'b0;
    #0.5;
    rst_n = 1'b0;
    #0.5;
    chk("R5 async red_vld", int'(red_vld), 0);
    chk("R5 async red pair", int'(red_tot), 0);
    chk("R5 async sum_vld", int'(sum_vld), 0);
    chk("R5 async sum_out", int'(sum_out), 0);
    tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R7: recovery with the largest operands
    comp_in = 24'hFF_FFFF;
    in_vld  = 1'b1;
    tick();
    in_vld = 1'b0;
    tick();
    chk("R7 sum_vld", int'(sum_vld), 1);
    chk("R7 max sum", int'(sum_out), 195075);

    report();
  end

endmodule